// File: doc/BRIEF.md
# Scalar Memory Request Tracker

This block sits between the unit that issues scalar memory instructions for a set of wavefronts and a scalar data memory port. Each issued request names a wavefront, an operation type and a return-bus hold duration. It enters an in-order issue queue. From there it is forwarded to memory one per cycle, subject to separate in-flight limits for the load class and the store class. Loads and both kinds of atomic belong to the load class.

Memory answers with responses that echo the request's type, wavefront and hold value. The echoed type steers each response into either a returned-load queue or a returned-store queue. One response per cycle is retired, and the returned-load queue always wins. Retirement waits for the register file to take the write and for the shared return bus to be idle. Unless co-issue return mode is on, it also waits for the scalar memory unit to be idle.

For each wavefront the block keeps three counts of pending work: reads, writes and total. The issuer uses these counts to throttle itself.

Top module: `smem_tracker`

## Requirements
- R1: After a synchronous active-low reset, all queues are empty, every in-flight and per-wavefront counter reads zero, `iss_full` is low, and neither `mem_req_valid` nor `ret_valid` is asserted.
- R2: Operation codes are 0 = load, 1 = store, 2 = atomic with return, 3 = atomic without return. A response with code 1 is placed in the returned-store queue; every other code goes to the returned-load queue. `ret_op` and `ret_wf` echo the retired entry.
- R3: The retire candidate is the head of the returned-load queue whenever that queue holds an entry. Only otherwise is it the head of the returned-store queue.
- R4: Loads and both atomic types share one in-flight counter (`ld_inflight`); stores use another (`st_inflight`). Each counter is raised when a request is sent and lowered when it retires, and neither exceeds `QSZ`.
- R5: When the issue-queue head belongs to a class whose in-flight counter equals `QSZ`, nothing is sent to memory. Younger requests behind it wait as well.
- R6: A candidate retires only when the return bus is idle and, unless `coissue` is high, the scalar memory unit is idle. Loads and atomics with return additionally need `rf_wr_ok` high. A blocked candidate blocks everything behind it.
- R7: A retire with hold value h keeps the return bus, and with `coissue` low also the memory unit, busy for h cycles. The next retire therefore comes no sooner than h+1 cycles later.
- R8: On acceptance into the issue queue, the named wavefront's total count rises by one. A load raises its read count, a store raises its write count, and either atomic raises both.
- R9: On retire, the wavefront's total count falls by one. Its read count falls for a load or atomic, and its write count falls for a store or atomic.
- R10: At most one request is sent to memory per cycle, and at most one entry retires per cycle.
- R11: `iss_full` is high while the issue queue holds `IQ_DEPTH` entries. A request offered while full is dropped and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issuer offers a request |
| iss_op | input | 2 | Operation code of offered request |
| iss_wf | input | WF_W | Wavefront id of offered request |
| iss_hold | input | HOLD_W | Return-bus hold duration for this operation |
| iss_full | output | 1 | Issue queue full; offers are dropped |
| mem_req_valid | output | 1 | Request presented to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_op | output | 2 | Operation code of presented request |
| mem_req_wf | output | WF_W | Wavefront id of presented request |
| mem_req_hold | output | HOLD_W | Hold value carried with the request |
| mem_rsp_valid | input | 1 | Memory presents a response |
| mem_rsp_ready | output | 1 | Target returned queue has room |
| mem_rsp_op | input | 2 | Echoed operation code |
| mem_rsp_wf | input | WF_W | Echoed wavefront id |
| mem_rsp_hold | input | HOLD_W | Echoed hold value |
| rf_wr_ok | input | 1 | Register file can accept a load write this cycle |
| coissue | input | 1 | Co-issue return mode; memory-unit busy is ignored |
| ret_valid | output | 1 | An entry retires this cycle |
| ret_op | output | 2 | Operation code of retiring entry |
| ret_wf | output | WF_W | Wavefront id of retiring entry |
| ld_inflight | output | IF_W | Load-class requests sent and not retired |
| st_inflight | output | IF_W | Store requests sent and not retired |
| rd_cnt | output | NUM_WF*CW | Per-wavefront outstanding read counts, wavefront w at bits [w*CW +: CW] |
| wr_cnt | output | NUM_WF*CW | Per-wavefront outstanding write counts, same packing |
| tot_cnt | output | NUM_WF*CW | Per-wavefront outstanding total counts, same packing |

## Verification
The checker watches a set of rules on every cycle. The in-flight caps must never be exceeded, and nothing may be sent while the head's class is at its cap. A store must never retire while a returned load waits. A retire must never happen while the bus is busy, while the memory unit is busy outside co-issue mode, or while a register-file write is needed and refused. A retire with a nonzero hold must not be followed by a retire in the next cycle. Some properties only the directed scenarios can show: the exact h+1 retire spacing, head-of-line blocking of a younger store behind a capped load, the routing of each operation code, and the way each code moves the per-wavefront read, write and total counts.

// File: rtl/smem_pkg.sv
// smem_pkg: operation codes and classification helpers shared by the
// scalar memory request tracker and its checker.
package smem_pkg;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'd0,
        OP_STORE    = 2'd1,
        OP_ATOM_RET = 2'd2,
        OP_ATOM_NR  = 2'd3
    } smem_op_e;

    localparam int OP_W = 2;

    // Load class: everything except a plain store.
    function automatic logic is_ld_class(input logic [1:0] op);
        return op != OP_STORE;
    endfunction

    // Operations that write the scalar register file at retire.
    function automatic logic needs_rf(input logic [1:0] op);
        return (op == OP_LOAD) || (op == OP_ATOM_RET);
    endfunction

    // Operations tracked as pending reads.
    function automatic logic counts_rd(input logic [1:0] op);
        return op != OP_STORE;
    endfunction

    // Operations tracked as pending writes.
    function automatic logic counts_wr(input logic [1:0] op);
        return op != OP_LOAD;
    endfunction

endpackage

// File: rtl/smem_fifo.sv
// smem_fifo: synchronous single-clock FIFO with show-ahead output.
// Assumes DEPTH >= 2. A push while full and a pop while empty are ignored.
module smem_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_q;
    logic [AW-1:0]    rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    logic do_push;
    logic do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_ptr_q];

    // Store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_ptr_q] <= din;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/smem_hold_timer.sv
// smem_hold_timer: down-counter marking a resource busy for a loaded
// number of cycles. A load of zero leaves the resource free.
module smem_hold_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] val,
    output logic              busy
);
    logic [HOLD_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Reload on a retire, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/smem_wf_counters.sv
// smem_wf_counters: per-wavefront pending read, write and total counts.
// Assumes CW is wide enough for the queues and caps in use, so no wrap.
module smem_wf_counters
    import smem_pkg::*;
#(
    parameter int NUM_WF = 4,
    parameter int WF_W   = 2,
    parameter int CW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inc_valid,
    input  logic [WF_W-1:0]      inc_wf,
    input  logic [1:0]           inc_op,
    input  logic                 dec_valid,
    input  logic [WF_W-1:0]      dec_wf,
    input  logic [1:0]           dec_op,
    output logic [NUM_WF*CW-1:0] rd_cnt,
    output logic [NUM_WF*CW-1:0] wr_cnt,
    output logic [NUM_WF*CW-1:0] tot_cnt
);
    for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
        logic [CW-1:0] rd_q;
        logic [CW-1:0] wr_q;
        logic [CW-1:0] tot_q;
        logic inc_hit;
        logic dec_hit;

        assign inc_hit = inc_valid && (inc_wf == WF_W'(w));
        assign dec_hit = dec_valid && (dec_wf == WF_W'(w));

        // Apply issue increments and retire decrements for this wavefront.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q  <= '0;
                wr_q  <= '0;
                tot_q <= '0;
            end else begin
                tot_q <= tot_q + CW'(inc_hit) - CW'(dec_hit);
                rd_q  <= rd_q + CW'(inc_hit && counts_rd(inc_op))
                              - CW'(dec_hit && counts_rd(dec_op));
                wr_q  <= wr_q + CW'(inc_hit && counts_wr(inc_op))
                              - CW'(dec_hit && counts_wr(dec_op));
            end
        end

        assign rd_cnt[w*CW +: CW]  = rd_q;
        assign wr_cnt[w*CW +: CW]  = wr_q;
        assign tot_cnt[w*CW +: CW] = tot_q;
    end

endmodule

// File: rtl/smem_tracker.sv
// smem_tracker: in-order issue of scalar memory requests with separate
// load-class and store in-flight caps, two returned queues with load
// priority at retire, retire gating on register file, return bus and
// memory unit, and per-wavefront pending counters.
// Assumes memory echoes op, wavefront and hold on each response.
module smem_tracker
    import smem_pkg::*;
#(
    parameter int NUM_WF   = 4,
    parameter int IQ_DEPTH = 4,
    parameter int RQ_DEPTH = 4,
    parameter int QSZ      = 2,
    parameter int HOLD_W   = 4,
    parameter int CW       = 4,
    parameter int WF_W     = (NUM_WF > 1) ? $clog2(NUM_WF) : 1,
    parameter int IF_W     = $clog2(QSZ + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [1:0]           iss_op,
    input  logic [WF_W-1:0]      iss_wf,
    input  logic [HOLD_W-1:0]    iss_hold,
    output logic                 iss_full,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [1:0]           mem_req_op,
    output logic [WF_W-1:0]      mem_req_wf,
    output logic [HOLD_W-1:0]    mem_req_hold,
    input  logic                 mem_rsp_valid,
    output logic                 mem_rsp_ready,
    input  logic [1:0]           mem_rsp_op,
    input  logic [WF_W-1:0]      mem_rsp_wf,
    input  logic [HOLD_W-1:0]    mem_rsp_hold,
    input  logic                 rf_wr_ok,
    input  logic                 coissue,
    output logic                 ret_valid,
    output logic [1:0]           ret_op,
    output logic [WF_W-1:0]      ret_wf,
    output logic [IF_W-1:0]      ld_inflight,
    output logic [IF_W-1:0]      st_inflight,
    output logic [NUM_WF*CW-1:0] rd_cnt,
    output logic [NUM_WF*CW-1:0] wr_cnt,
    output logic [NUM_WF*CW-1:0] tot_cnt
);
    localparam int ENT_W = OP_W + WF_W + HOLD_W;

    // Issue queue
    logic             iq_push;
    logic             iq_empty;
    logic [ENT_W-1:0] iq_dout;
    logic             head_ld;
    logic             send;

    // Returned queues
    logic             rsp_to_st;
    logic             ldq_push, stq_push;
    logic             ldq_pop, stq_pop;
    logic             ldq_empty, stq_empty;
    logic             ldq_full, stq_full;
    logic [ENT_W-1:0] ldq_dout, stq_dout;

    // Retire candidate
    logic              use_ld;
    logic              cand_valid;
    logic [ENT_W-1:0]  cand;
    logic [1:0]        cand_op;
    logic [WF_W-1:0]   cand_wf;
    logic [HOLD_W-1:0] cand_hold;
    logic              ret_fire;
    logic              bus_busy;
    logic              unit_busy;

    logic [IF_W-1:0] ld_if_q;
    logic [IF_W-1:0] st_if_q;

    assign iq_push = iss_valid && !iss_full;

    smem_fifo #(.W(ENT_W), .DEPTH(IQ_DEPTH)) iq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (iq_push),
        .din   ({iss_op, iss_wf, iss_hold}),
        .pop   (send),
        .dout  (iq_dout),
        .empty (iq_empty),
        .full  (iss_full)
    );

    assign {mem_req_op, mem_req_wf, mem_req_hold} = iq_dout;
    assign head_ld = is_ld_class(mem_req_op);

    // Present the head only if its class has room below the cap.
    always_comb begin
        if (iq_empty) begin
            mem_req_valid = 1'b0;
        end else if (head_ld) begin
            mem_req_valid = (ld_if_q < IF_W'(QSZ));
        end else begin
            mem_req_valid = (st_if_q < IF_W'(QSZ));
        end
    end

    assign send = mem_req_valid && mem_req_ready;

    // Route responses by the echoed op code.
    assign rsp_to_st     = (mem_rsp_op == OP_STORE);
    assign mem_rsp_ready = rsp_to_st ? !stq_full : !ldq_full;
    assign ldq_push      = mem_rsp_valid && !rsp_to_st && !ldq_full;
    assign stq_push      = mem_rsp_valid && rsp_to_st && !stq_full;

    smem_fifo #(.W(ENT_W), .DEPTH(RQ_DEPTH)) ldq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ldq_push),
        .din   ({mem_rsp_op, mem_rsp_wf, mem_rsp_hold}),
        .pop   (ldq_pop),
        .dout  (ldq_dout),
        .empty (ldq_empty),
        .full  (ldq_full)
    );

    smem_fifo #(.W(ENT_W), .DEPTH(RQ_DEPTH)) stq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stq_push),
        .din   ({mem_rsp_op, mem_rsp_wf, mem_rsp_hold}),
        .pop   (stq_pop),
        .dout  (stq_dout),
        .empty (stq_empty),
        .full  (stq_full)
    );

    // Candidate: returned-load head first, else returned-store head.
    assign use_ld     = !ldq_empty;
    assign cand_valid = !ldq_empty || !stq_empty;
    assign cand       = use_ld ? ldq_dout : stq_dout;
    assign {cand_op, cand_wf, cand_hold} = cand;

    assign ret_fire = cand_valid && !bus_busy
                   && (!needs_rf(cand_op) || rf_wr_ok)
                   && (coissue || !unit_busy);

    assign ldq_pop   = ret_fire && use_ld;
    assign stq_pop   = ret_fire && !use_ld;
    assign ret_valid = ret_fire;
    assign ret_op    = cand_op;
    assign ret_wf    = cand_wf;

    // Track load-class and store requests between send and retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_if_q <= '0;
            st_if_q <= '0;
        end else begin
            ld_if_q <= ld_if_q + IF_W'(send && head_ld) - IF_W'(ldq_pop);
            st_if_q <= st_if_q + IF_W'(send && !head_ld) - IF_W'(stq_pop);
        end
    end

    assign ld_inflight = ld_if_q;
    assign st_inflight = st_if_q;

    smem_hold_timer #(.HOLD_W(HOLD_W)) bus_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ret_fire),
        .val   (cand_hold),
        .busy  (bus_busy)
    );

    smem_hold_timer #(.HOLD_W(HOLD_W)) unit_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ret_fire && !coissue),
        .val   (cand_hold),
        .busy  (unit_busy)
    );

    smem_wf_counters #(.NUM_WF(NUM_WF), .WF_W(WF_W), .CW(CW)) wfc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (iq_push),
        .inc_wf    (iss_wf),
        .inc_op    (iss_op),
        .dec_valid (ret_fire),
        .dec_wf    (cand_wf),
        .dec_op    (cand_op),
        .rd_cnt    (rd_cnt),
        .wr_cnt    (wr_cnt),
        .tot_cnt   (tot_cnt)
    );

endmodule

// File: rtl/smem_tracker_chk.sv
// smem_tracker_chk: cycle-by-cycle properties of the tracker, bound to
// every instance of smem_tracker.
module smem_tracker_chk
    import smem_pkg::*;
#(
    parameter int QSZ    = 2,
    parameter int IF_W   = 2,
    parameter int HOLD_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic [1:0]        mem_req_op,
    input logic [IF_W-1:0]   ld_inflight,
    input logic [IF_W-1:0]   st_inflight,
    input logic              ret_valid,
    input logic [1:0]        ret_op,
    input logic [HOLD_W-1:0] ret_hold,
    input logic              rf_wr_ok,
    input logic              coissue,
    input logic              bus_busy,
    input logic              unit_busy,
    input logic              ldq_empty
);
    a_r4_ld_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ld_inflight <= IF_W'(QSZ));

    a_r4_st_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_inflight <= IF_W'(QSZ));

    a_r5_ld_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && is_ld_class(mem_req_op)) |-> (ld_inflight < IF_W'(QSZ)));

    a_r5_st_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !is_ld_class(mem_req_op)) |-> (st_inflight < IF_W'(QSZ)));

    a_r3_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_op == OP_STORE) |-> ldq_empty);

    a_r6_rf_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && needs_rf(ret_op)) |-> rf_wr_ok);

    a_r6_bus_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !bus_busy);

    a_r6_unit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !coissue) |-> !unit_busy);

    a_r7_hold_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_hold != '0) |=> !ret_valid);

endmodule

bind smem_tracker smem_tracker_chk #(
    .QSZ    (QSZ),
    .IF_W   (IF_W),
    .HOLD_W (HOLD_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_op    (mem_req_op),
    .ld_inflight   (ld_inflight),
    .st_inflight   (st_inflight),
    .ret_valid     (ret_valid),
    .ret_op        (ret_op),
    .ret_hold      (cand_hold),
    .rf_wr_ok      (rf_wr_ok),
    .coissue       (coissue),
    .bus_busy      (bus_busy),
    .unit_busy     (unit_busy),
    .ldq_empty     (ldq_empty)
);

// File: tb/smem_tracker_tb_top.sv
// Directed bench for smem_tracker: one task per scenario.
module smem_tracker_tb_top;
    localparam int NUM_WF = 4;
    localparam int QSZ    = 2;
    localparam int HOLD_W = 4;
    localparam int CW     = 4;
    localparam int WF_W   = 2;
    localparam int IF_W   = $clog2(QSZ + 1);

    localparam logic [1:0] LD = 2'd0;
    localparam logic [1:0] ST = 2'd1;
    localparam logic [1:0] AR = 2'd2;
    localparam logic [1:0] AN = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [1:0] iss_op = '0;
    logic [WF_W-1:0] iss_wf = '0;
    logic [HOLD_W-1:0] iss_hold = '0;
    logic iss_full;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [1:0] mem_req_op;
    logic [WF_W-1:0] mem_req_wf;
    logic [HOLD_W-1:0] mem_req_hold;
    logic mem_rsp_valid = 1'b0;
    logic mem_rsp_ready;
    logic [1:0] mem_rsp_op = '0;
    logic [WF_W-1:0] mem_rsp_wf = '0;
    logic [HOLD_W-1:0] mem_rsp_hold = '0;
    logic rf_wr_ok = 1'b1;
    logic coissue = 1'b0;
    logic ret_valid;
    logic [1:0] ret_op;
    logic [WF_W-1:0] ret_wf;
    logic [IF_W-1:0] ld_inflight;
    logic [IF_W-1:0] st_inflight;
    logic [NUM_WF*CW-1:0] rd_cnt;
    logic [NUM_WF*CW-1:0] wr_cnt;
    logic [NUM_WF*CW-1:0] tot_cnt;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smem_tracker #(
        .NUM_WF(NUM_WF), .IQ_DEPTH(4), .RQ_DEPTH(4), .QSZ(QSZ),
        .HOLD_W(HOLD_W), .CW(CW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_wf(iss_wf),
        .iss_hold(iss_hold), .iss_full(iss_full),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_req_wf(mem_req_wf),
        .mem_req_hold(mem_req_hold),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_op(mem_rsp_op), .mem_rsp_wf(mem_rsp_wf),
        .mem_rsp_hold(mem_rsp_hold),
        .rf_wr_ok(rf_wr_ok), .coissue(coissue),
        .ret_valid(ret_valid), .ret_op(ret_op), .ret_wf(ret_wf),
        .ld_inflight(ld_inflight), .st_inflight(st_inflight),
        .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .tot_cnt(tot_cnt)
    );

    task automatic chk(input int got, input int exp, input string what);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    function automatic int rdc(input int w);
        return int'(rd_cnt[w*CW +: CW]);
    endfunction
    function automatic int wrc(input int w);
        return int'(wr_cnt[w*CW +: CW]);
    endfunction
    function automatic int totc(input int w);
        return int'(tot_cnt[w*CW +: CW]);
    endfunction

    // All tasks start just after a falling edge and end on one.
    task automatic issue(input logic [1:0] op, input int wf, input int hold);
        iss_valid = 1'b1;
        iss_op = op;
        iss_wf = WF_W'(wf);
        iss_hold = HOLD_W'(hold);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic send(input logic [1:0] op, input int wf, input string tag);
        mem_req_ready = 1'b1;
        #1;
        chk(int'(mem_req_valid), 1, {tag, " request presented"});
        chk(int'(mem_req_op), int'(op), {tag, " request op"});
        chk(int'(mem_req_wf), wf, {tag, " request wf"});
        @(negedge clk);
        mem_req_ready = 1'b0;
    endtask

    task automatic respond(input logic [1:0] op, input int wf, input int hold);
        mem_rsp_valid = 1'b1;
        mem_rsp_op = op;
        mem_rsp_wf = WF_W'(wf);
        mem_rsp_hold = HOLD_W'(hold);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    task automatic expect_ret(input logic [1:0] op, input int wf, input string tag);
        #1;
        chk(int'(ret_valid), 1, {tag, " retire valid"});
        chk(int'(ret_op), int'(op), {tag, " retire op"});
        chk(int'(ret_wf), wf, {tag, " retire wf"});
        @(negedge clk);
    endtask

    task automatic expect_idle(input string tag);
        #1;
        chk(int'(ret_valid), 0, {tag, " no retire"});
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(int'(iss_full), 0, "R1 iss_full");
        chk(int'(mem_req_valid), 0, "R1 mem_req_valid");
        chk(int'(ret_valid), 0, "R1 ret_valid");
        chk(int'(ld_inflight), 0, "R1 ld_inflight");
        chk(int'(st_inflight), 0, "R1 st_inflight");
        for (int w = 0; w < NUM_WF; w++) begin
            chk(totc(w) + rdc(w) + wrc(w), 0, "R1 wavefront counters");
        end
    endtask

    task automatic t_basic_load;
        issue(LD, 1, 0);
        chk(totc(1), 1, "R8 load total");
        chk(rdc(1), 1, "R8 load read");
        chk(wrc(1), 0, "R8 load write");
        send(LD, 1, "R4 load");
        chk(int'(ld_inflight), 1, "R4 ld_inflight after send");
        respond(LD, 1, 0);
        expect_ret(LD, 1, "R2 load");
        chk(totc(1), 0, "R9 load total");
        chk(rdc(1), 0, "R9 load read");
        chk(int'(ld_inflight), 0, "R4 ld_inflight after retire");
    endtask

    task automatic t_basic_store;
        issue(ST, 2, 0);
        chk(wrc(2), 1, "R8 store write");
        chk(rdc(2), 0, "R8 store read");
        send(ST, 2, "R4 store");
        chk(int'(st_inflight), 1, "R4 st_inflight after send");
        chk(int'(ld_inflight), 0, "R4 store not in load count");
        respond(ST, 2, 0);
        expect_ret(ST, 2, "R2 store");
        chk(wrc(2), 0, "R9 store write");
        chk(int'(st_inflight), 0, "R4 st_inflight after retire");
    endtask

    task automatic t_atomics;
        issue(AR, 3, 0);
        issue(AN, 3, 0);
        chk(rdc(3), 2, "R8 atomic read");
        chk(wrc(3), 2, "R8 atomic write");
        chk(totc(3), 2, "R8 atomic total");
        send(AR, 3, "R4 atomic-ret");
        send(AN, 3, "R4 atomic-noret");
        chk(int'(ld_inflight), 2, "R4 atomics count as load class");
        chk(int'(st_inflight), 0, "R4 atomics not store class");
        rf_wr_ok = 1'b0;
        respond(AN, 3, 0);
        expect_ret(AN, 3, "R6 atomic-noret needs no rf");
        respond(AR, 3, 0);
        expect_idle("R6 atomic-ret waits for rf");
        expect_idle("R6 atomic-ret still waits");
        rf_wr_ok = 1'b1;
        expect_ret(AR, 3, "R6 atomic-ret after rf ok");
        chk(rdc(3), 0, "R9 atomic read");
        chk(wrc(3), 0, "R9 atomic write");
        chk(totc(3), 0, "R9 atomic total");
    endtask

    task automatic t_cap_and_order;
        issue(LD, 0, 0);
        issue(LD, 0, 0);
        issue(LD, 0, 0);
        issue(ST, 0, 0);
        chk(int'(iss_full), 1, "R11 iss_full at depth");
        chk(totc(0), 4, "R8 total of four");
        issue(ST, 1, 0);
        chk(totc(1), 0, "R11 dropped offer total");
        chk(wrc(1), 0, "R11 dropped offer write");
        send(LD, 0, "R10 first");
        chk(int'(ld_inflight), 1, "R10 one send per cycle");
        send(LD, 0, "R10 second");
        chk(int'(ld_inflight), 2, "R4 ld_inflight at cap");
        mem_req_ready = 1'b1;
        #1;
        chk(int'(mem_req_valid), 0, "R5 stall at cap");
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(int'(st_inflight), 0, "R5 younger store not bypassing");
        chk(int'(iss_full), 0, "R11 full drops after sends");
        respond(LD, 0, 0);
        expect_ret(LD, 0, "R5 first load back");
        send(LD, 0, "R5 third load released");
        send(ST, 0, "R5 store after loads");
        respond(LD, 0, 0);
        expect_ret(LD, 0, "R9 second load");
        respond(LD, 0, 0);
        expect_ret(LD, 0, "R9 third load");
        respond(ST, 0, 0);
        expect_ret(ST, 0, "R9 store");
        chk(totc(0), 0, "R9 wf0 drained");
    endtask

    task automatic t_priority;
        issue(ST, 1, 0);
        issue(LD, 2, 0);
        send(ST, 1, "R3 store");
        send(LD, 2, "R3 load");
        rf_wr_ok = 1'b0;
        respond(LD, 2, 0);
        respond(ST, 1, 0);
        expect_idle("R3 store held behind blocked load");
        rf_wr_ok = 1'b1;
        expect_ret(LD, 2, "R3 load first");
        expect_ret(ST, 1, "R3 store second");
    endtask

    task automatic t_hold;
        issue(ST, 0, 3);
        issue(ST, 0, 0);
        send(ST, 0, "R7 first");
        send(ST, 0, "R7 second");
        respond(ST, 0, 3);
        expect_ret(ST, 0, "R7 first retire");
        respond(ST, 0, 0);
        expect_idle("R7 hold cycle");
        expect_idle("R7 hold last cycle");
        expect_ret(ST, 0, "R7 retire after h+1");
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_load();
        t_basic_store();
        t_atomics();
        t_cap_and_order();
        t_priority();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule